// File: doc/BRIEF.md
# GPIO Port with Interrupt Sensing

A 32-pin general-purpose I/O port controlled through a small word-addressed register bus. Software sets an output value and a per-pin direction; pins whose direction bit is set drive the output value onto the pad with their output enable asserted, and all other pins are inputs. The pad levels are brought into the clock domain through a two-flop synchronizer and can be read back from a read-only level register. This register is separate from the output value register, so the output value always reads back as it was written.

Every pin can raise an interrupt. A 2-bit sense code per pin selects low level, high level, rising edge or falling edge. The codes for pins 0 to 15 are packed into one configuration word and the codes for pins 16 to 31 into a second word. A separate any-edge register makes a pin react to both edges and overrides its code. Detected events are latched in a pending register that software clears by writing ones. An enable register gates the pending bits onto two interrupt lines: one serves the lower sixteen pins and the other the upper sixteen. Level events are latched again on every cycle that the level is present, so a level interrupt cannot be cleared until the pad changes. An edge is latched once.

Top module: `gpio_sense_port`

## Requirements
- R1: Registers sit at byte offsets 0x00 output value, 0x04 direction, 0x08 pad level (read-only), 0x0C sense codes for pins 0-15, 0x10 sense codes for pins 16-31, 0x14 interrupt enable, 0x18 pending, 0x1C any-edge select. Any other offset, including one that is not a multiple of 4, reads as zero, and a write to it changes nothing. A write to 0x08 changes nothing.
- R2: Reading 0x00 returns the last value written there, not the pad level. `pad_out` equals that value and `pad_oe` equals the direction register, bit for bit.
- R3: The pad level register shows `pad_in` after two clock edges. After a pad change, a read taken after one edge still shows the old level and a read taken after two edges shows the new one.
- R4: Pin n uses bits [2*(n mod 16)+1 : 2*(n mod 16)] of the word at 0x0C for n < 16, and of the word at 0x10 otherwise. The code is 0 = low level, 1 = high level, 2 = rising edge, 3 = falling edge. A rising-edge pin ignores a falling edge, and a falling-edge pin ignores a rising edge.
- R5: A pin whose any-edge bit is 1 latches both rising and falling edges, and its sense code has no effect, including a low-level code while the pad is low.
- R6: Writing 0x18 clears each pending bit written as 1 and leaves each bit written as 0 unchanged. Writing all ones clears every pending bit whose event is no longer present.
- R7: In a level mode the pending bit is set again on every cycle that the level is present, so clearing it while the level persists leaves it set. Once the level is gone, clearing it takes effect.
- R8: An edge sets the pending bit once. After it is cleared, the bit stays clear until a new qualifying edge arrives.
- R9: `irq_lo` is the OR over pins 0-15 of pending AND enable, and `irq_hi` is the same for pins 16-31. A pin whose enable bit is 0 never raises a line.
- R10: Reset clears the output value, direction, both sense words, enable, pending and any-edge registers to zero, and holds both interrupt lines and all output enables low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the register at `bus_addr` |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Output value driven to the pads |
| pad_oe | output | 32 | Per-pin output enable |
| irq_lo | output | 1 | Interrupt line for pins 0-15 |
| irq_hi | output | 1 | Interrupt line for pins 16-31 |

## Verification
The bench clears a level-mode pin while its level is still present and expects the bit to stay set. A design that let the clear win over the new event would drop a live level interrupt. It also clears an edge-mode pin and waits several cycles to catch a design that latches the level instead of the edge. The any-edge override is tested with the pin's code set to low level and the pad held low, which exposes a design that still honours the code. The code fields for pin 17 and pin 20 in the upper word catch off-by-one field slicing. The enable test raises an upper-half event with its enable off, then turns the enable on, so a crossed or unmasked line shows up at once.

// File: rtl/gpio_sense_pkg.sv
package gpio_sense_pkg;

   // Byte offsets of the register window; software decodes these.
   localparam int OFS_OUTVAL   = 'h00;
   localparam int OFS_DIR      = 'h04;
   localparam int OFS_PADLVL   = 'h08;
   localparam int OFS_SENSE_LO = 'h0C;
   localparam int OFS_SENSE_HI = 'h10;
   localparam int OFS_ENABLE   = 'h14;
   localparam int OFS_PENDING  = 'h18;
   localparam int OFS_ANYEDGE  = 'h1C;

   localparam int SENSE_W = 2;

   typedef enum logic [SENSE_W-1:0] {
      SENSE_LOW  = 2'd0,
      SENSE_HIGH = 2'd1,
      SENSE_RISE = 2'd2,
      SENSE_FALL = 2'd3
   } sense_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= async_in;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_sense_pkg::*;
#(
   parameter int NUM_PINS = 32,
   parameter int ADDR_W   = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [NUM_PINS-1:0] bus_wdata,
   output logic [NUM_PINS-1:0] bus_rdata,
   input  logic [NUM_PINS-1:0] pad_level,
   input  logic [NUM_PINS-1:0] pending,
   output logic [NUM_PINS-1:0] outval_q,
   output logic [NUM_PINS-1:0] dir_q,
   output logic [NUM_PINS-1:0] sense_lo_q,
   output logic [NUM_PINS-1:0] sense_hi_q,
   output logic [NUM_PINS-1:0] enable_q,
   output logic [NUM_PINS-1:0] anyedge_q,
   output logic [NUM_PINS-1:0] clr_mask
);

   localparam logic [ADDR_W-1:0] A_OUTVAL   = ADDR_W'(OFS_OUTVAL);
   localparam logic [ADDR_W-1:0] A_DIR      = ADDR_W'(OFS_DIR);
   localparam logic [ADDR_W-1:0] A_PADLVL   = ADDR_W'(OFS_PADLVL);
   localparam logic [ADDR_W-1:0] A_SENSE_LO = ADDR_W'(OFS_SENSE_LO);
   localparam logic [ADDR_W-1:0] A_SENSE_HI = ADDR_W'(OFS_SENSE_HI);
   localparam logic [ADDR_W-1:0] A_ENABLE   = ADDR_W'(OFS_ENABLE);
   localparam logic [ADDR_W-1:0] A_PENDING  = ADDR_W'(OFS_PENDING);
   localparam logic [ADDR_W-1:0] A_ANYEDGE  = ADDR_W'(OFS_ANYEDGE);

   logic hit_outval, hit_dir, hit_lo, hit_hi, hit_en, hit_pend, hit_any;

   assign hit_outval = (bus_addr == A_OUTVAL);
   assign hit_dir    = (bus_addr == A_DIR);
   assign hit_lo     = (bus_addr == A_SENSE_LO);
   assign hit_hi     = (bus_addr == A_SENSE_HI);
   assign hit_en     = (bus_addr == A_ENABLE);
   assign hit_pend   = (bus_addr == A_PENDING);
   assign hit_any    = (bus_addr == A_ANYEDGE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         outval_q   <= '0;
         dir_q      <= '0;
         sense_lo_q <= '0;
         sense_hi_q <= '0;
         enable_q   <= '0;
         anyedge_q  <= '0;
      end else if (bus_wr) begin
         if (hit_outval) outval_q   <= bus_wdata;
         if (hit_dir)    dir_q      <= bus_wdata;
         if (hit_lo)     sense_lo_q <= bus_wdata;
         if (hit_hi)     sense_hi_q <= bus_wdata;
         if (hit_en)     enable_q   <= bus_wdata;
         if (hit_any)    anyedge_q  <= bus_wdata;
      end
   end

   // Write-one-to-clear request, consumed by the pending register.
   assign clr_mask = (bus_wr && hit_pend) ? bus_wdata : '0;

   always_comb begin
      bus_rdata = '0;
      if (hit_outval)                   bus_rdata = outval_q;
      else if (hit_dir)                 bus_rdata = dir_q;
      else if (bus_addr == A_PADLVL)    bus_rdata = pad_level;
      else if (hit_lo)                  bus_rdata = sense_lo_q;
      else if (hit_hi)                  bus_rdata = sense_hi_q;
      else if (hit_en)                  bus_rdata = enable_q;
      else if (hit_pend)                bus_rdata = pending;
      else if (hit_any)                 bus_rdata = anyedge_q;
   end

   AST_OUTVAL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_OUTVAL) |=> (outval_q == $past(bus_wdata))); // R2

   AST_MISALIGNED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr[1:0] != 2'b00) |-> (bus_rdata == '0)); // R1

   AST_MISALIGNED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr[1:0] != 2'b00) |=> $stable(outval_q) && $stable(enable_q)); // R1

endmodule

// File: rtl/gpio_sense_bank.sv
module gpio_sense_bank
   import gpio_sense_pkg::*;
#(
   parameter int NUM_PINS = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] level,
   input  logic [NUM_PINS-1:0] sense_lo,
   input  logic [NUM_PINS-1:0] sense_hi,
   input  logic [NUM_PINS-1:0] anyedge,
   output logic [NUM_PINS-1:0] event_hit
);

   localparam int HALF = NUM_PINS / 2;

   logic [NUM_PINS-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level;
   end

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      logic [SENSE_W-1:0] code;
      if (i < HALF) begin : g_lo
         assign code = sense_lo[SENSE_W*i +: SENSE_W];
      end else begin : g_hi
         assign code = sense_hi[SENSE_W*(i-HALF) +: SENSE_W];
      end

      logic rise, fall;
      assign rise = level[i] & ~prev_q[i];
      assign fall = ~level[i] & prev_q[i];

      always_comb begin
         if (anyedge[i]) begin
            event_hit[i] = rise | fall;
         end else begin
            unique case (sense_e'(code))
               SENSE_LOW:  event_hit[i] = ~level[i];
               SENSE_HIGH: event_hit[i] = level[i];
               SENSE_RISE: event_hit[i] = rise;
               SENSE_FALL: event_hit[i] = fall;
               default:    event_hit[i] = 1'b0;
            endcase
         end
      end

      AST_ANYEDGE_SEES_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
         (anyedge[i] && (level[i] != prev_q[i])) |-> event_hit[i]); // R5

      AST_ANYEDGE_STEADY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         (anyedge[i] && (level[i] == prev_q[i])) |-> !event_hit[i]); // R5
   end

endmodule

// File: rtl/gpio_pending.sv
module gpio_pending #(
   parameter int NUM_PINS = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] event_hit,
   input  logic [NUM_PINS-1:0] clr_mask,
   input  logic [NUM_PINS-1:0] enable,
   output logic [NUM_PINS-1:0] pending_q,
   output logic                irq_lo,
   output logic                irq_hi
);

   localparam int HALF = NUM_PINS / 2;

   logic [NUM_PINS-1:0] live;

   // A new event in the same cycle as a clear keeps the bit set.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pending_q <= '0;
      else        pending_q <= (pending_q & ~clr_mask) | event_hit;
   end

   assign live   = pending_q & enable;
   assign irq_lo = |live[HALF-1:0];
   assign irq_hi = |live[NUM_PINS-1:HALF];

   AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pending_q & $past(event_hit)) == $past(event_hit))); // R7

   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pending_q & $past(clr_mask & ~event_hit)) == '0)); // R6

   AST_UNCLEARED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((pending_q & $past(pending_q & ~clr_mask)) == $past(pending_q & ~clr_mask))); // R6

endmodule

// File: rtl/gpio_sense_port.sv
module gpio_sense_port
   import gpio_sense_pkg::*;
#(
   parameter int NUM_PINS    = 32,
   parameter int ADDR_W      = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [NUM_PINS-1:0] bus_wdata,
   output logic [NUM_PINS-1:0] bus_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic                irq_lo,
   output logic                irq_hi
);

   localparam int CODES_PER_WORD = NUM_PINS / SENSE_W;

   if (NUM_PINS != 2 * CODES_PER_WORD || NUM_PINS % SENSE_W != 0) begin : g_bad_pins
      $error("gpio_sense_port: two sense words must cover exactly NUM_PINS pins");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("gpio_sense_port: ADDR_W must reach offset 0x1C");
   end

   logic [NUM_PINS-1:0] level;
   logic [NUM_PINS-1:0] pending;
   logic [NUM_PINS-1:0] outval, dir, sense_lo, sense_hi, enable, anyedge;
   logic [NUM_PINS-1:0] clr_mask, event_hit;

   gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pad_in),
      .sync_out (level)
   );

   gpio_regfile #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .pad_level  (level),
      .pending    (pending),
      .outval_q   (outval),
      .dir_q      (dir),
      .sense_lo_q (sense_lo),
      .sense_hi_q (sense_hi),
      .enable_q   (enable),
      .anyedge_q  (anyedge),
      .clr_mask   (clr_mask)
   );

   gpio_sense_bank #(.NUM_PINS(NUM_PINS)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .level     (level),
      .sense_lo  (sense_lo),
      .sense_hi  (sense_hi),
      .anyedge   (anyedge),
      .event_hit (event_hit)
   );

   gpio_pending #(.NUM_PINS(NUM_PINS)) u_pend (
      .clk       (clk),
      .rst_n     (rst_n),
      .event_hit (event_hit),
      .clr_mask  (clr_mask),
      .enable    (enable),
      .pending_q (pending),
      .irq_lo    (irq_lo),
      .irq_hi    (irq_hi)
   );

   assign pad_out = outval;
   assign pad_oe  = dir;

   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (enable == '0) |-> (!irq_lo && !irq_hi)); // R9

   AST_PENDING_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_hi) |-> (pending != '0)); // R9

endmodule

// File: tb/test_gpio_sense_port.sv
module test_gpio_sense_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_out, pad_oe;
   logic        irq_lo, irq_hi;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   localparam logic [4:0] A_OUT = 5'h00, A_DIR = 5'h04, A_LVL = 5'h08, A_SLO = 5'h0C,
                          A_SHI = 5'h10, A_EN = 5'h14, A_PEND = 5'h18, A_ANY = 5'h1C;

   always #4 clk = ~clk;

   gpio_sense_port i_gpio_sense_port (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic all_rise_clear();
      wr(A_ANY, 32'h0);
      wr(A_SLO, 32'hAAAA_AAAA);
      wr(A_SHI, 32'hAAAA_AAAA);
      wr(A_PEND, 32'hFFFF_FFFF);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      repeat (3) @(negedge clk);
      check("R10 pad_oe in reset", pad_oe, 32'h0);
      check("R10 pad_out in reset", pad_out, 32'h0);
      check("R10 irq lines in reset", {30'h0, irq_hi, irq_lo}, 32'h0);
      rd(A_SLO, v);  check("R10 sense lo reset", v, 32'h0);
      rd(A_EN, v);   check("R10 enable reset", v, 32'h0);
      rd(A_PEND, v); check("R10 pending reset", v, 32'h0);
      rd(A_ANY, v);  check("R10 anyedge reset", v, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_regmap();
      logic [31:0] v;
      wr(A_SLO, 32'h5555_0000);
      wr(A_SHI, 32'h0000_5555);
      wr(A_EN,  32'h8000_0001);
      wr(A_ANY, 32'h0F0F_0000);
      wr(A_OUT, 32'hA5A5_0001);
      rd(A_SLO, v); check("R1 sense lo at 0x0C", v, 32'h5555_0000);
      rd(A_SHI, v); check("R1 sense hi at 0x10", v, 32'h0000_5555);
      rd(A_EN,  v); check("R1 enable at 0x14", v, 32'h8000_0001);
      rd(A_ANY, v); check("R1 anyedge at 0x1C", v, 32'h0F0F_0000);
      rd(5'h02, v); check("R1 misaligned read zero", v, 32'h0);
      rd(5'h1D, v); check("R1 misaligned high read zero", v, 32'h0);
      wr(5'h01, 32'hFFFF_FFFF);
      rd(A_OUT, v); check("R1 misaligned write ignored", v, 32'hA5A5_0001);
      wr(A_LVL, 32'hFFFF_FFFF);
      rd(A_LVL, v); check("R1 pad level read-only", v, 32'h0);
      wr(A_EN, 32'h0);
   endtask

   task automatic t_data_dir();
      logic [31:0] v;
      wr(A_OUT, 32'h1234_5678);
      wr(A_DIR, 32'hFFFF_0000);
      rd(A_OUT, v); check("R2 output value readback not pad", v, 32'h1234_5678);
      check("R2 pad_out", pad_out, 32'h1234_5678);
      check("R2 pad_oe", pad_oe, 32'hFFFF_0000);
      wr(A_DIR, 32'h0);
      check("R2 pad_oe released", pad_oe, 32'h0);
   endtask

   task automatic t_pad_level();
      logic [31:0] v;
      @(negedge clk);
      pad_in = 32'h8000_0001;
      @(negedge clk);
      rd(A_LVL, v); check("R3 level after one edge still old", v, 32'h0);
      @(negedge clk);
      rd(A_LVL, v); check("R3 level after two edges", v, 32'h8000_0001);
      pad_in = 32'h0;
      settle();
   endtask

   task automatic t_rise();
      logic [31:0] v;
      all_rise_clear();
      rd(A_PEND, v); check("R6 all-ones clear", v, 32'h0);
      pad_in[5] = 1'b1; settle();
      rd(A_PEND, v); check("R4 rising edge pin 5", v, 32'h20);
      wr(A_PEND, 32'h20); settle();
      rd(A_PEND, v); check("R8 edge latched once", v, 32'h0);
      pad_in[5] = 1'b0; settle();
      rd(A_PEND, v); check("R4 rising pin ignores fall", v, 32'h0);
   endtask

   task automatic t_fall();
      logic [31:0] v;
      wr(A_SHI, 32'hAAAA_AAAE);
      pad_in[17] = 1'b1; settle();
      rd(A_PEND, v); check("R4 falling pin ignores rise", v, 32'h0);
      pad_in[17] = 1'b0; settle();
      rd(A_PEND, v); check("R4 falling edge pin 17", v, 32'h0002_0000);
      wr(A_SHI, 32'hAAAA_AAAA);
      wr(A_PEND, 32'hFFFF_FFFF);
   endtask

   task automatic t_level();
      logic [31:0] v;
      wr(A_SLO, 32'hAAAA_AA6A);
      settle();
      rd(A_PEND, v); check("R4 high level idle when low", v, 32'h0);
      pad_in[3] = 1'b1; settle();
      rd(A_PEND, v); check("R4 high level pin 3", v, 32'h8);
      wr(A_PEND, 32'h8);
      rd(A_PEND, v); check("R7 level re-sets after clear", v, 32'h8);
      pad_in[3] = 1'b0; settle();
      wr(A_PEND, 32'h8);
      rd(A_PEND, v); check("R7 clear once level gone", v, 32'h0);
      wr(A_SLO, 32'hAAAA_AAAA);
      wr(A_SHI, 32'hAAAA_A8AA);
      settle();
      rd(A_PEND, v); check("R4 low level pin 20", v, 32'h0010_0000);
      pad_in[20] = 1'b1; settle();
      wr(A_PEND, 32'h0010_0000);
      rd(A_PEND, v); check("R7 low level cleared after pad high", v, 32'h0);
      wr(A_SHI, 32'hAAAA_AAAA);
      pad_in[20] = 1'b0; settle();
      wr(A_PEND, 32'hFFFF_FFFF);
   endtask

   task automatic t_both();
      logic [31:0] v;
      wr(A_ANY, 32'h0000_0300);
      wr(A_SLO, 32'hAAA2_AAAA);
      wr(A_PEND, 32'hFFFF_FFFF);
      settle();
      rd(A_PEND, v); check("R5 low code ignored under any-edge", v, 32'h0);
      pad_in[8] = 1'b1; settle();
      rd(A_PEND, v); check("R5 any-edge rise pin 8", v, 32'h100);
      wr(A_PEND, 32'h100);
      pad_in[8] = 1'b0; settle();
      rd(A_PEND, v); check("R5 any-edge fall pin 8", v, 32'h100);
      all_rise_clear();
   endtask

   task automatic t_w1c();
      logic [31:0] v;
      pad_in[5] = 1'b1; pad_in[6] = 1'b1; settle();
      rd(A_PEND, v); check("R6 two pending", v, 32'h60);
      wr(A_PEND, 32'h40);
      rd(A_PEND, v); check("R6 zero bits unchanged", v, 32'h20);
      wr(A_PEND, 32'hFFFF_FFFF);
      rd(A_PEND, v); check("R6 all ones clears", v, 32'h0);
      pad_in[5] = 1'b0; pad_in[6] = 1'b0; settle();
   endtask

   task automatic t_irq();
      wr(A_EN, 32'h20);
      pad_in[5] = 1'b1; settle();
      check("R9 irq_lo from enabled pin 5", {31'h0, irq_lo}, 32'h1);
      check("R9 irq_hi quiet", {31'h0, irq_hi}, 32'h0);
      pad_in[17] = 1'b1; settle();
      check("R9 disabled pin 17 stays off", {31'h0, irq_hi}, 32'h0);
      wr(A_EN, 32'h0002_0020);
      check("R9 irq_hi after enabling 17", {31'h0, irq_hi}, 32'h1);
      wr(A_PEND, 32'h20);
      check("R9 irq_lo drops on clear", {31'h0, irq_lo}, 32'h0);
      check("R9 irq_hi stays", {31'h0, irq_hi}, 32'h1);
      wr(A_PEND, 32'hFFFF_FFFF);
      check("R9 both lines low", {30'h0, irq_hi, irq_lo}, 32'h0);
      pad_in = 32'h0;
      wr(A_EN, 32'h0);
   endtask

   initial begin
      t_reset();
      t_regmap();
      t_data_dir();
      t_pad_level();
      t_rise();
      t_fall();
      t_level();
      t_both();
      t_w1c();
      t_irq();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule